// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital core of a 32-position digitally controlled potentiometer. Three asynchronous control pins drive it: an active-low select, a step strobe and a direction level. While the block is selected, every falling edge of the step strobe moves a saturating wiper position one place up or one place down. The position is decoded onto a one-hot tap-select bus that drives the switch network of a resistor ladder.

Releasing the select pin while the step strobe is high saves the current position into a register that models nonvolatile storage. The save then runs a store cycle of fixed length, with a busy flag raised for the whole cycle. Releasing the select pin while the strobe is low only returns the block to standby, and nothing is saved.

A functional reset reloads the wiper from the saved value. A separate power-on reset sets both the saved value and the wiper to a parameter value. All three control pins pass through two synchroniser stages before their edges are detected.

Top module: `wiper_ctrl`

## Requirements
- R1: `tap_sel` always has exactly one bit set. Bit number `wiper_pos` is the set bit, and the position spans 0 to TAPS-1 (0 to 31 by default).
- R2: While the synchronised `sel_n` is high, edges on `step` and changes on `dir_up` leave `wiper_pos` unchanged.
- R3: While `sel_n` is low and no store is running, each high-to-low transition of `step` moves `wiper_pos` by exactly one. `step` is sampled at clock edge m, and the new position is visible after edge m+2.
- R4: With `dir_up` = 1 a step increments the position (toward the high terminal). With `dir_up` = 0 a step decrements it.
- R5: The position saturates. A step up at TAPS-1 leaves it at TAPS-1, and a step down at 0 leaves it at 0.
- R6: A low-to-high transition of `sel_n` while `step` is high starts a store. `store_busy` is high for exactly STORE_CYCLES clock cycles, starting after edge m+2 for a release sampled at edge m. When the store ends, `saved_pos` takes the position held when the store started.
- R7: A low-to-high transition of `sel_n` while `step` is low starts no store. `store_busy` stays low and `saved_pos` keeps its value.
- R8: Asserting `rst_n` low loads `wiper_pos` from `saved_pos` and abandons any store in progress. `rst_n` never changes `saved_pos`.
- R9: Asserting `por_n` low sets both `saved_pos` and `wiper_pos` to NV_INIT (16 by default) and clears `store_busy`.
- R10: While `store_busy` is high, step edges and select releases are ignored. The position does not move, and no further store is started.
- R11: `saved_pos` changes only on the clock edge that ends a store cycle, or under power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; initialises the saved value |
| rst_n | input | 1 | Functional reset, active low, synchronous; recalls the saved value |
| sel_n | input | 1 | Select, active low, asynchronous |
| step | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down, asynchronous |
| wiper_pos | output | $clog2(TAPS) | Current wiper position |
| tap_sel | output | TAPS | One-hot tap select |
| store_busy | output | 1 | High while a store cycle is running |
| saved_pos | output | $clog2(TAPS) | Contents of the modelled nonvolatile register |

## Verification
The hardest case to reach is a step or a second select release that arrives inside a running store cycle. Such an event must leave no trace, both during the cycle and after it ends. The bench reaches it by releasing `sel_n` with `step` high and waiting for the busy flag. It then reselects, pulses `step` and releases `sel_n` again well inside the store window. A behavioural model that mirrors the synchroniser latency is compared with the outputs every clock. It shows whether the position moved, whether busy ran longer than STORE_CYCLES, and whether the saved value took the position captured at the first release.

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 10000,
  parameter int NV_INIT      = 16
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     sel_n,
  input  logic                     step,
  input  logic                     dir_up,
  output logic [$clog2(TAPS)-1:0]  wiper_pos,
  output logic [TAPS-1:0]          tap_sel,
  output logic                     store_busy,
  output logic [$clog2(TAPS)-1:0]  saved_pos
);

  localparam int PW = $clog2(TAPS);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [PW-1:0] TOP   = PW'(TAPS - 1);
  localparam logic [PW-1:0] INITV = PW'(NV_INIT);
  localparam logic [CW-1:0] LAST  = CW'(STORE_CYCLES - 1);

  logic          rst_any;
  logic [2:0]    sel_sh, stp_sh;
  logic [1:0]    dir_sh;
  logic [PW-1:0] pos, nv, pend;
  logic [CW-1:0] cnt;
  logic          busy, rdy;
  logic          step_fall, sel_rise, do_step, do_store, store_end;

  assign rst_any = !por_n || !rst_n;

  // two sync stages, third stage holds the previous value for edge detect
  always_ff @(posedge clk) begin
    if (rst_any) begin
      sel_sh <= 3'b111;
      stp_sh <= 3'b111;
      dir_sh <= 2'b00;
    end else begin
      sel_sh <= {sel_sh[1:0], sel_n};
      stp_sh <= {stp_sh[1:0], step};
      dir_sh <= {dir_sh[0], dir_up};
    end
  end

  assign step_fall = stp_sh[2] & ~stp_sh[1];
  assign sel_rise  = sel_sh[1] & ~sel_sh[2];
  assign do_step   = ~sel_sh[1] & step_fall & ~busy;
  assign do_store  = sel_rise & stp_sh[1] & ~busy;
  assign store_end = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!por_n)
      pos <= INITV;
    else if (!rst_n)
      pos <= nv;
    else if (do_step) begin
      if (dir_sh[1] && pos != TOP)
        pos <= pos + 1'b1;
      else if (!dir_sh[1] && pos != '0)
        pos <= pos - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      busy <= 1'b0;
      cnt  <= '0;
      pend <= '0;
    end else if (busy) begin
      if (cnt == '0)
        busy <= 1'b0;
      else
        cnt <= cnt - 1'b1;
    end else if (do_store) begin
      busy <= 1'b1;
      cnt  <= LAST;
      pend <= pos;
    end
  end

  // modelled nonvolatile cell: only power-on reset initialises it
  always_ff @(posedge clk) begin
    if (!por_n)
      nv <= INITV;
    else if (rst_n && store_end)
      nv <= pend;
  end

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      assign tap_sel[gi] = (pos == PW'(gi));
    end
  endgenerate

  assign wiper_pos  = pos;
  assign store_busy = busy;
  assign saved_pos  = nv;

  always_ff @(posedge clk) begin
    if (rst_any) rdy <= 1'b0;
    else         rdy <= 1'b1;
  end

  a_r1_one_tap: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    $countones(tap_sel) == 1 && tap_sel[pos]);

  a_r2_no_move_deselected: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    sel_sh[1] |=> $stable(wiper_pos));

  a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    wiper_pos == TOP |=> wiper_pos >= TOP - 1'b1);

  a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    wiper_pos == '0 |=> wiper_pos <= PW'(1));

  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    store_busy |=> $stable(wiper_pos));

  a_r11_nv_hold: assert property (@(posedge clk) disable iff (rst_any || !rdy)
    !store_end |=> $stable(saved_pos));

endmodule

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int TAPS   = 32;
  localparam int SC     = 24;
  localparam int INIT   = 16;

  logic clk = 0, por_n = 0, rst_n = 1, sel_n = 1, step = 1, dir_up = 0;
  logic [4:0]  wiper_pos, saved_pos;
  logic [31:0] tap_sel;
  logic        store_busy;

  wiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(SC), .NV_INIT(INIT)) u_wiper_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_n(sel_n), .step(step),
    .dir_up(dir_up), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
    .store_busy(store_busy), .saved_pos(saved_pos));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, cmp_en = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: input history with two-sample latency
  bit h_sel[4], h_stp[4], h_dir[4];
  int m_pos = INIT, m_nv = INIT, m_pend = 0, m_cnt = 0;
  bit m_busy = 0;

  always @(posedge clk) begin
    bit cs, ps, ci, pi, cd;
    for (int i = 3; i > 0; i--) begin
      h_sel[i] = h_sel[i-1]; h_stp[i] = h_stp[i-1]; h_dir[i] = h_dir[i-1];
    end
    if (!por_n || !rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_sel[i] = 1; h_stp[i] = 1; h_dir[i] = 0;
      end
    end else begin
      h_sel[0] = sel_n; h_stp[0] = step; h_dir[0] = dir_up;
    end
    cs = h_sel[2]; ps = h_sel[3]; ci = h_stp[2]; pi = h_stp[3]; cd = h_dir[2];
    if (!por_n) begin
      m_nv = INIT; m_pos = INIT; m_busy = 0;
    end else if (!rst_n) begin
      m_pos = m_nv; m_busy = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin m_nv = m_pend; m_busy = 0; end
      else m_cnt--;
    end else begin
      if (!cs && pi && !ci) begin
        if (cd && m_pos < TAPS - 1) m_pos++;
        else if (!cd && m_pos > 0) m_pos--;
      end
      if (cs && !ps && ci) begin
        m_busy = 1; m_pend = m_pos; m_cnt = SC - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R3 R4 model position", wiper_pos, m_pos);
      chk("R1 model tap", (tap_sel == (32'h1 << m_pos)) ? 1 : 0, 1);
      chk("R6 model busy", store_busy, m_busy);
      chk("R11 model saved", saved_pos, m_nv);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      step = 0; cyc(4);
      step = 1; cyc(4);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    por_n = 0; cyc(3); por_n = 1; cmp_en = 1; cyc(2);
    chk("R9 por position", wiper_pos, 16);
    chk("R9 por saved", saved_pos, 16);
    chk("R1 tap at 16", (tap_sel == 32'h0001_0000) ? 1 : 0, 1);
    chk("R9 busy low", store_busy, 0);

    sel_n = 0; dir_up = 1; cyc(4);
    pulse(3);
    chk("R4 up three", wiper_pos, 19);
    chk("R1 tap at 19", (tap_sel == 32'h0008_0000) ? 1 : 0, 1);

    step = 0; cyc(2);
    chk("R3 not yet moved", wiper_pos, 19);
    cyc(1);
    chk("R3 moved on third edge", wiper_pos, 20);
    step = 1; cyc(4);

    dir_up = 0; cyc(2); pulse(5);
    chk("R4 down five", wiper_pos, 15);

    dir_up = 1; cyc(2); pulse(20);
    chk("R5 top saturate", wiper_pos, 31);
    pulse(1);
    chk("R5 top stays", wiper_pos, 31);

    step = 0; cyc(4); sel_n = 1; cyc(6);
    chk("R7 no store busy", store_busy, 0);
    step = 1; cyc(30);
    chk("R7 saved unchanged", saved_pos, 16);

    dir_up = 0; pulse(3);
    chk("R2 deselected no move", wiper_pos, 31);

    sel_n = 0; cyc(4); pulse(2);
    chk("R4 down two", wiper_pos, 29);
    sel_n = 1; cyc(3);
    chk("R6 busy raised", store_busy, 1);
    sel_n = 0; cyc(2); pulse(1);
    chk("R10 step ignored", wiper_pos, 29);
    chk("R11 saved before end", saved_pos, 16);
    cyc(30);
    chk("R6 busy ended", store_busy, 0);
    chk("R6 saved value", saved_pos, 29);

    dir_up = 1; cyc(2); pulse(1);
    chk("R4 up one", wiper_pos, 30);
    rst_n = 0; cyc(2); rst_n = 1; cyc(2);
    chk("R8 recall", wiper_pos, 29);
    chk("R8 saved kept", saved_pos, 29);

    sel_n = 0; cyc(4); pulse(1);
    sel_n = 1; cyc(3);
    chk("R6 second busy", store_busy, 1);
    sel_n = 0; cyc(4); pulse(1); sel_n = 1; cyc(25);
    chk("R10 no restart", store_busy, 0);
    chk("R10 pos held", wiper_pos, 30);
    chk("R6 saved 30", saved_pos, 30);
    cyc(30);
    chk("R10 still idle", store_busy, 0);

    por_n = 0; cyc(2); por_n = 1; cyc(2);
    chk("R9 por again pos", wiper_pos, 16);
    chk("R9 por again saved", saved_pos, 16);

    sel_n = 0; dir_up = 0; cyc(4); pulse(17);
    chk("R5 bottom saturate", wiper_pos, 0);
    pulse(1);
    chk("R5 bottom stays", wiper_pos, 0);
    chk("R1 tap at 0", (tap_sel == 32'h1) ? 1 : 0, 1);

    cyc(4);
    finish_run();
  end
endmodule